// File: doc/BRIEF.md
# Sound Unit Register Bank with Power Gating

This block is the processor-side register file of a four-channel sound unit. A byte bus with a single address selects one of twenty channel and mixer registers, a master control register, or one byte of a small waveform memory. Writes take effect on the clock edge. Reads are combinational from the same address. Every register value goes out on a flat port so that the tone generators can use it. The generators return per-channel activity flags, plus the playing state, the readability condition and the sample window position of the wave channel.

Two behaviours set this bank apart from a plain register file. The first is that read-back fills unused bits with ones. The second is that the master power bit gates writes: while the unit is off, writes to channel and mixer registers store zero. In the original-model style there are exceptions for the length fields. While the wave channel plays, a waveform access is redirected to the byte under the playback window. The parameter `ORIG_STYLE` chooses between the original-model rules and the later rules. Waveform memory accesses are never gated by power.

Local map. Channel 1: 0 sweep, 1 duty/length, 2 envelope, 3 period low, 4 trigger. Channel 2: 5 duty/length, 6 envelope, 7 period low, 8 trigger. Channel 3: 9 wave enable, 10 wave length, 11 level, 12 period low, 13 trigger. Channel 4: 14 noise length, 15 envelope, 16 noise shape, 17 trigger. Mixer: 18 volume, 19 panning. 20 master control. 0x20 to 0x2F waveform bytes.

Top module: `snd_regbank`

## Requirements
- R1: A read of register 0..19 returns the stored byte OR a fixed mask. The masks are: sweep 0x80; both duty/length registers 0x3F; the three period-low registers, wave length and noise length 0xFF; the four trigger registers 0xBF; wave enable 0x7F; level 0x9F; envelope, noise shape, volume and panning 0x00.
- R2: A read from any address that is not 0..20 and not a waveform byte (0x15..0x1F, 0x30..0x3F) returns 0xFF.
- R3: While power is off, a write to a channel or mixer register stores 0, except as R4 allows.
- R4: While power is off with ORIG_STYLE=1, a write to a duty/length register (1, 5) stores only its low 6 bits, and a write to wave length (10) or noise length (14) stores the full byte. With ORIG_STYLE=0 these writes also store 0.
- R5: Only bit 7 (power) of master control (20) is writable. Its read value is {power, 3'b111, chan_active[3:0]}.
- R6: A write of master control with bit 7 clear turns power off and clears all twenty channel and mixer registers, visible on regs_o after that edge.
- R7: While wave_playing is 0, waveform byte 0x20+i is read and written at index i.
- R8: While wave_playing is 1 with ORIG_STYLE=1, a waveform access goes to index wave_pos>>1 if wave_readable is 1. Otherwise a read returns 0xFF and a write is dropped.
- R9: While wave_playing is 1 with ORIG_STYLE=0, every waveform access goes to index wave_pos>>1, whatever wave_readable is.
- R10: wave_sel_o always equals wave_pos>>1, and waveform writes work whatever the power state.
- R11: After reset, power is off, every channel and mixer register is 0 and every waveform byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Byte address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| chan_active | input | 4 | Activity flags of the four channels |
| wave_playing | input | 1 | Wave channel is running |
| wave_readable | input | 1 | Waveform memory is accessible while running |
| wave_pos | input | POS_W (5) | Sample window position, two samples per byte |
| regs_o | output | 160 | Registers 0..19, register n at bits 8n+7:8n |
| power_o | output | 1 | Master power state |
| wave_sel_o | output | IDX_W (4) | Waveform byte under the window |

## Verification
The bench builds two copies of the block side by side with WAVE_BYTES=16: one with ORIG_STYLE=1 and one with ORIG_STYLE=0. Both copies get the same stimulus, so each gated write and each waveform access during playback shows the two rule sets against each other in the same cycle. The powered-off length exceptions and the readable/unreadable split only differ between the copies, and comparing the regs_o bytes exposes the length fields that the read masks hide.

// File: rtl/snd_regs_pkg.sv
package snd_regs_pkg;
  localparam int DW        = 8;
  localparam int NREG      = 20;
  localparam int A_MASTER  = 20;
  localparam int ADDR_W    = 6;
  localparam logic [ADDR_W-1:0] WAVE_BASE = 6'h20;

  typedef enum logic [1:0] {K_PLAIN, K_DUTYLEN, K_LENGTH} reg_kind_t;

  function automatic reg_kind_t reg_kind(input logic [4:0] idx);
    case (idx)
      5'd1, 5'd5:   return K_DUTYLEN;
      5'd10, 5'd14: return K_LENGTH;
      default:      return K_PLAIN;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_mask(input logic [4:0] idx);
    case (idx)
      5'd0:                         return 8'h80;
      5'd1, 5'd5:                   return 8'h3F;
      5'd3, 5'd7, 5'd12:            return 8'hFF;
      5'd10, 5'd14:                 return 8'hFF;
      5'd4, 5'd8, 5'd13, 5'd17:     return 8'hBF;
      5'd9:                         return 8'h7F;
      5'd11:                        return 8'h9F;
      default:                      return 8'h00;
    endcase
  endfunction

  // value kept by a write that arrives while the unit is unpowered
  function automatic logic [DW-1:0] off_value(input reg_kind_t k,
                                              input logic [DW-1:0] d,
                                              input bit orig);
    case (k)
      K_DUTYLEN: return orig ? {2'b00, d[5:0]} : 8'h00;
      K_LENGTH:  return orig ? d : 8'h00;
      default:   return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/snd_ctl_regs.sv
module snd_ctl_regs
  import snd_regs_pkg::*;
#(
  parameter bit ORIG_STYLE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_go,
  input  logic [4:0]         wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] regs_flat,
  output logic               pwr,
  output logic               pwr_off_evt
);
  logic [DW-1:0] regs [NREG];
  logic          master_wr;
  logic          chan_wr;
  logic [DW-1:0] gated;

  assign master_wr   = wr_go && (wr_idx == 5'(A_MASTER));
  assign chan_wr     = wr_go && (wr_idx < 5'(NREG));
  assign pwr_off_evt = master_wr && !wr_data[7];

  always_comb begin
    gated = pwr ? wr_data : off_value(reg_kind(wr_idx), wr_data, ORIG_STYLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (master_wr) pwr <= wr_data[7];
      if (pwr_off_evt) begin
        for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (chan_wr) begin
        regs[wr_idx] <= gated;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = regs[g];
  end
endmodule

// File: rtl/snd_wave_ram.sv
module snd_wave_ram
  import snd_regs_pkg::*;
#(
  parameter int WAVE_BYTES = 16,
  parameter bit ORIG_STYLE = 1'b1,
  localparam int IDX_W = $clog2(WAVE_BYTES),
  localparam int POS_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  logic [IDX_W-1:0] lo_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             playing,
  input  logic             readable,
  input  logic [POS_W-1:0] pos,
  output logic [DW-1:0]    rd_byte,
  output logic [IDX_W-1:0] win_idx,
  output logic             access_ok
);
  logic [DW-1:0]    ram [WAVE_BYTES];
  logic [IDX_W-1:0] eff_idx;

  always_comb begin
    win_idx   = pos[POS_W-1:1];
    access_ok = !playing || !ORIG_STYLE || readable;
    eff_idx   = playing ? win_idx : lo_idx;
    rd_byte   = access_ok ? ram[eff_idx] : 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WAVE_BYTES; i++) ram[i] <= '0;
    end else if (wr_go && access_ok) begin
      ram[eff_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/snd_regbank.sv
module snd_regbank
  import snd_regs_pkg::*;
#(
  parameter int WAVE_BYTES = 16,
  parameter bit ORIG_STYLE = 1'b1,
  localparam int IDX_W = $clog2(WAVE_BYTES),
  localparam int POS_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  input  logic [3:0]         chan_active,
  input  logic               wave_playing,
  input  logic               wave_readable,
  input  logic [POS_W-1:0]   wave_pos,
  output logic [NREG*DW-1:0] regs_o,
  output logic               power_o,
  output logic [IDX_W-1:0]   wave_sel_o
);
  logic          reg_hit;
  logic          master_hit;
  logic          wave_hit;
  logic          pwr_off_evt;
  logic          wave_ok;
  logic [DW-1:0] wave_rd;

  assign reg_hit    = (addr[5] == 1'b0) && (addr[4:0] < 5'(NREG));
  assign master_hit = (addr == ADDR_W'(A_MASTER));
  assign wave_hit   = (int'(addr) >= int'(WAVE_BASE)) &&
                      (int'(addr) <  int'(WAVE_BASE) + WAVE_BYTES);

  snd_ctl_regs #(.ORIG_STYLE(ORIG_STYLE)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_go       (wr_en && (reg_hit || master_hit)),
    .wr_idx      (addr[4:0]),
    .wr_data     (wr_data),
    .regs_flat   (regs_o),
    .pwr         (power_o),
    .pwr_off_evt (pwr_off_evt)
  );

  snd_wave_ram #(.WAVE_BYTES(WAVE_BYTES), .ORIG_STYLE(ORIG_STYLE)) u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go     (wr_en && wave_hit),
    .lo_idx    (addr[IDX_W-1:0]),
    .wr_data   (wr_data),
    .playing   (wave_playing),
    .readable  (wave_readable),
    .pos       (wave_pos),
    .rd_byte   (wave_rd),
    .win_idx   (wave_sel_o),
    .access_ok (wave_ok)
  );

  always_comb begin
    rd_data = 8'hFF;
    if (reg_hit)
      rd_data = regs_o[int'(addr[4:0])*DW +: DW] | reg_mask(addr[4:0]);
    else if (master_hit)
      rd_data = {power_o, 3'b111, chan_active};
    else if (wave_hit)
      rd_data = wave_rd;
  end
endmodule

// File: rtl/snd_regbank_chk.sv
module snd_regbank_chk
  import snd_regs_pkg::*;
#(
  parameter int WAVE_BYTES = 16,
  parameter bit ORIG_STYLE = 1'b1,
  localparam int IDX_W = $clog2(WAVE_BYTES),
  localparam int POS_W = IDX_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr,
  input logic               wr_en,
  input logic [DW-1:0]      rd_data,
  input logic [3:0]         chan_active,
  input logic               wave_playing,
  input logic               wave_readable,
  input logic [NREG*DW-1:0] regs_o,
  input logic               power_o,
  input logic               pwr_off_evt
);
  logic in_wave;
  logic unmapped;
  assign in_wave  = (int'(addr) >= int'(WAVE_BASE)) &&
                    (int'(addr) <  int'(WAVE_BASE) + WAVE_BYTES);
  assign unmapped = (int'(addr) > A_MASTER) && !in_wave;

  assert_unmapped_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> rd_data == 8'hFF);

  assert_power_off_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_evt |=> (regs_o == '0) && !power_o);

  assert_off_write_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!power_o && wr_en && addr == '0) |=> regs_o[DW-1:0] == '0);

  assert_master_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(A_MASTER)) |-> rd_data[6:0] == {3'b111, chan_active});

  assert_wave_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ORIG_STYLE && wave_playing && !wave_readable && in_wave) |-> rd_data == 8'hFF);
endmodule

bind snd_regbank snd_regbank_chk #(.WAVE_BYTES(WAVE_BYTES), .ORIG_STYLE(ORIG_STYLE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr          (addr),
  .wr_en         (wr_en),
  .rd_data       (rd_data),
  .chan_active   (chan_active),
  .wave_playing  (wave_playing),
  .wave_readable (wave_readable),
  .regs_o        (regs_o),
  .power_o       (power_o),
  .pwr_off_evt   (pwr_off_evt)
);

// File: tb/tb_snd_regbank.sv
module tb_snd_regbank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_data = '0;
  logic [3:0]   chan = '0;
  logic         playing = 1'b0;
  logic         readable = 1'b0;
  logic [4:0]   pos = '0;
  logic [7:0]   rd_a, rd_b;
  logic [159:0] regs_a, regs_b;
  logic         pwr_a, pwr_b;
  logic [3:0]   sel_a, sel_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_regs [2][20];
  bit         m_pwr [2];
  logic [7:0] m_wave [2][16];

  always #5 clk = ~clk;

  snd_regbank #(.WAVE_BYTES(16), .ORIG_STYLE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_a), .chan_active(chan), .wave_playing(playing),
    .wave_readable(readable), .wave_pos(pos), .regs_o(regs_a),
    .power_o(pwr_a), .wave_sel_o(sel_a));

  snd_regbank #(.WAVE_BYTES(16), .ORIG_STYLE(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_b), .chan_active(chan), .wave_playing(playing),
    .wave_readable(readable), .wave_pos(pos), .regs_o(regs_b),
    .power_o(pwr_b), .wave_sel_o(sel_b));

  function automatic logic [7:0] f_mask(int i);
    case (i)
      0: return 8'h80;
      1, 5: return 8'h3F;
      3, 7, 12, 10, 14: return 8'hFF;
      4, 8, 13, 17: return 8'hBF;
      9: return 8'h7F;
      11: return 8'h9F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] f_unpowered(int i, logic [7:0] d, bit orig);
    if (!orig) return 8'h00;
    if (i == 1 || i == 5) return d & 8'h3F;
    if (i == 10 || i == 14) return d;
    return 8'h00;
  endfunction

  // k = 0: original-model copy, k = 1: later-rule copy
  function automatic bit f_wave_ok(int k);
    return !playing || k == 1 || readable;
  endfunction

  function automatic logic [7:0] f_read(int k, int a);
    if (a < 20) return m_regs[k][a] | f_mask(a);
    if (a == 20) return {m_pwr[k], 3'b111, chan};
    if (a >= 32 && a < 48) begin
      if (!playing) return m_wave[k][a-32];
      if (f_wave_ok(k)) return m_wave[k][pos >> 1];
      return 8'hFF;
    end
    return 8'hFF;
  endfunction

  function automatic void m_write(int k, int a, logic [7:0] d);
    if (a < 20) begin
      m_regs[k][a] = m_pwr[k] ? d : f_unpowered(a, d, k == 0);
    end else if (a == 20) begin
      m_pwr[k] = d[7];
      if (!d[7]) for (int i = 0; i < 20; i++) m_regs[k][i] = 8'h00;
    end else if (a >= 32 && a < 48) begin
      if (!playing) m_wave[k][a-32] = d;
      else if (f_wave_ok(k)) m_wave[k][pos >> 1] = d;
    end
  endfunction

  task automatic check(string req, logic [159:0] act, logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = 6'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    m_write(0, a, d);
    m_write(1, a, d);
  endtask

  task automatic rd_check(string req, int a);
    @(negedge clk);
    addr = 6'(a);
    #1;
    check(req, 160'(rd_a), 160'(f_read(0, a)));
    check(req, 160'(rd_b), 160'(f_read(1, a)));
  endtask

  task automatic regs_check(string req);
    logic [159:0] ea, eb;
    for (int i = 0; i < 20; i++) begin
      ea[i*8 +: 8] = m_regs[0][i];
      eb[i*8 +: 8] = m_regs[1][i];
    end
    check(req, regs_a, ea);
    check(req, regs_b, eb);
    check(req, 160'(pwr_a), 160'(m_pwr[0]));
    check(req, 160'(pwr_b), 160'(m_pwr[1]));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < 2; k++) begin
      m_pwr[k] = 0;
      for (int i = 0; i < 20; i++) m_regs[k][i] = 8'h00;
      for (int i = 0; i < 16; i++) m_wave[k][i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    regs_check("R11");
    rd_check("R11 R5", 20);
    rd_check("R11 R1", 0);
    rd_check("R11 R7", 37);

    // R2 unmapped holes
    rd_check("R2", 21);
    rd_check("R2", 31);
    rd_check("R2", 48);
    rd_check("R2", 63);

    // R3 / R4 gated writes while unpowered
    wr(2, 8'hF3);  rd_check("R3", 2);
    wr(18, 8'h77); rd_check("R3", 18);
    wr(1, 8'hC5);  wr(5, 8'h9A);
    wr(10, 8'hAB); wr(14, 8'h5A);
    regs_check("R4");

    // R10 waveform writable while unpowered
    wr(33, 8'h3C); rd_check("R10 R7", 33);

    // R5 power on, status bits live
    wr(20, 8'h8F);
    chan = 4'hA;
    rd_check("R5", 20);
    check("R5", 160'(pwr_a), 160'(1'b1));

    // R1 masks with all-zero and all-one contents
    for (int i = 0; i < 20; i++) begin
      wr(i, 8'h00); rd_check("R1", i);
    end
    for (int i = 0; i < 20; i++) begin
      wr(i, 8'hFF); rd_check("R1", i);
    end
    regs_check("R1");

    // R6 power-off clears everything
    wr(20, 8'h7F);
    regs_check("R6");
    rd_check("R6 R5", 20);

    // R7 direct waveform access while stopped
    for (int i = 0; i < 16; i++) wr(32 + i, 8'(i * 17 + 3));
    for (int i = 0; i < 16; i++) rd_check("R7", 32 + i);

    // R8 / R9 redirect while playing
    @(negedge clk);
    playing = 1'b1; pos = 5'd5; readable = 1'b1;
    #1;
    check("R10", 160'(sel_a), 160'(4'd2));
    check("R10", 160'(sel_b), 160'(4'd2));
    rd_check("R8 R9", 39);
    wr(43, 8'h99);
    rd_check("R8 R9", 32);
    @(negedge clk);
    readable = 1'b0;
    rd_check("R8 R9", 45);
    wr(32, 8'h11);
    @(negedge clk);
    playing = 1'b0;
    rd_check("R8 R9", 34);
    rd_check("R8 R9", 32);

    // mixed random traffic
    for (int it = 0; it < 800; it++) begin
      int a;
      logic [7:0] d;
      @(negedge clk);
      chan     = 4'($urandom);
      playing  = ($urandom % 4) == 0;
      readable = 1'($urandom);
      pos      = 5'($urandom);
      #1;
      check("R10", 160'(sel_a), 160'(pos >> 1));
      d = 8'($urandom);
      case ($urandom % 4)
        0: a = 20;
        1: a = 32 + int'($urandom % 16);
        default: a = int'($urandom % 64);
      endcase
      wr(a, d);
      regs_check("R3 R4 R6");
      rd_check("R1 R2 R5 R7 R8 R9", int'($urandom % 64));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule